// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

The block gathers 64 level-sensitive request lines and gives the processor a single interrupt level and vector number. Each source has an 8-bit priority that software programs. Writing any nonzero priority also enables the source, and writing zero disables it. A source competes when it is pending or forced, enabled, and unmasked. Among the competing sources, the one with the greatest priority wins. When two or more sources share that priority, the one with the highest index wins.

Software reaches the block through a simple 32-bit register bus inside a 256-byte window. Writes take effect on the clock edge. Reads return data combinationally. One read-only offset returns the vector now presented to the processor, so software can acknowledge the interrupt without the processor's own acknowledge cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each clock, the pending register takes the value of the request lines, so it follows line level with no latching. Offset 0x00 reads pending[63:32] and offset 0x04 reads pending[31:0].
- R2: Source n is a candidate only when (pending[n] OR force[n]) is 1, its priority is nonzero, and mask[n] is 0.
- R3: A write to offset 0x40+n stores wdata[7:0] as the priority of source n. A read of that offset returns the priority in bits [7:0], with the upper bits zero. A zero priority takes the source out of the competition.
- R4: The winner is the candidate with the greatest priority. On equal priorities, the higher source index wins.
- R5: `irq_level` shows the winner's priority and `irq_vector` shows 64 plus the winner's index. With no candidate, they show 0 and 24. Both outputs are registered: they reflect the state one clock after that state changes.
- R6: A write to offset 0x08 replaces mask[63:32]. A write to offset 0x0C replaces mask[31:0]. Reads of these offsets return the same halves.
- R7: A write to offset 0x10 replaces force[63:32]. A write to offset 0x14 replaces force[31:0]. Reads of these offsets return the same halves.
- R8: Writes to offsets 0x00 and 0x04, and to any unmapped offset, change no state. Reads of unmapped offsets return 0.
- R9: A read at offset 0xE0 returns the current `irq_vector`, zero-extended.
- R10: After reset, the mask is all ones, and pending, force and all priorities are zero. The level is 0 and the vector is 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Level-sensitive request lines |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_level | output | 8 | Priority of the winning source, 0 when idle |
| irq_vector | output | 8 | Vector number, 64+index or 24 when idle |

## Verification
Random request lines are crossed with random priorities drawn from a narrow range of 0 to 3. This makes ties and zero-priority sources common, so the tie rule and the zero-disables rule are separated from a plain highest-level pick. Mask and force values are randomized on their own, so that gating by mask and injection by force are told apart from pending. Directed sequences cover the following cases:
- an exact two-way tie, where the higher index must win;
- a forced source with no request line;
- clearing the winner's priority, after which the lower index must take over;
- writes to the pending offsets and to unmapped offsets, which must leave all readable state unchanged.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC     = 64,
  parameter int LVLW     = 8,
  parameter int VECW     = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_IDLE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      irq_in,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [LVLW-1:0]  irq_level,
  output logic [VECW-1:0]  irq_vector
);
  localparam int IDXW = $clog2(NSRC);

  logic [NSRC-1:0] pend, mask, frc, en, cand;
  logic [LVLW-1:0] prio [NSRC];
  logic [LVLW-1:0] best_lvl;
  logic [IDXW-1:0] best_idx;
  logic            hit;
  logic            armed;

  wire wr_prio = bus_wr && (bus_addr[7:6] == 2'b01);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign en[g] = |prio[g];
    always_ff @(posedge clk) begin
      if (!rst_n)                                  prio[g] <= '0;
      else if (wr_prio && bus_addr[5:0] == 6'(g))  prio[g] <= bus_wdata[LVLW-1:0];
    end
  end

  assign cand = (pend | frc) & en & ~mask;

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    hit      = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && prio[i] >= best_lvl) begin
        best_lvl = prio[i];
        best_idx = IDXW'(i);
        hit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      mask       <= '1;
      frc        <= '0;
      irq_level  <= '0;
      irq_vector <= VECW'(VEC_IDLE);
      armed      <= 1'b0;
    end else begin
      armed      <= 1'b1;
      pend       <= irq_in;
      irq_level  <= hit ? best_lvl : '0;
      irq_vector <= hit ? VECW'(VEC_BASE + int'(best_idx)) : VECW'(VEC_IDLE);
      if (bus_wr) begin
        case (bus_addr)
          8'h08: mask[63:32] <= bus_wdata;
          8'h0C: mask[31:0]  <= bus_wdata;
          8'h10: frc[63:32]  <= bus_wdata;
          8'h14: frc[31:0]   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:6] == 2'b01) bus_rdata = 32'(prio[bus_addr[5:0]]);
    else begin
      case (bus_addr)
        8'h00: bus_rdata = pend[63:32];
        8'h04: bus_rdata = pend[31:0];
        8'h08: bus_rdata = mask[63:32];
        8'h0C: bus_rdata = mask[31:0];
        8'h10: bus_rdata = frc[63:32];
        8'h14: bus_rdata = frc[31:0];
        8'hE0: bus_rdata = 32'(irq_vector);
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> pend == $past(irq_in));
  a_r2_idle_when_no_cand: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((irq_level == '0) == ($past(cand) == '0)));
  a_r5_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> (irq_vector == VECW'(VEC_IDLE)));
  a_r5_active_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_vector >= VECW'(VEC_BASE)));
  a_r6_mask_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_wr && bus_addr == 8'h0C) |=> (mask[31:0] == $past(bus_wdata)));
  a_r7_force_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_wr && bus_addr == 8'h10) |=> (frc[63:32] == $past(bus_wdata)));
  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h20) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [63:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  irq_level, irq_vector;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .irq_vector(irq_vector));

  logic [63:0] m_pend, m_mask, m_frc;
  logic [7:0]  m_prio [64];
  logic [7:0]  m_lvl, m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '1; m_frc = '0; m_lvl = 0; m_vec = 24;
      for (int i = 0; i < 64; i++) m_prio[i] = 0;
    end else begin
      int lvl, idx;
      lvl = 0; idx = -1;
      for (int i = 0; i < 64; i++)
        if ((m_pend[i] || m_frc[i]) && m_prio[i] != 0 && !m_mask[i] && m_prio[i] >= lvl) begin
          lvl = m_prio[i]; idx = i;
        end
      m_lvl = 8'(lvl);
      m_vec = (idx < 0) ? 8'd24 : 8'(64 + idx);
      m_pend = irq_in;
      if (bus_wr) begin
        if (bus_addr >= 8'h40 && bus_addr < 8'h80) m_prio[bus_addr - 8'h40] = bus_wdata[7:0];
        else if (bus_addr == 8'h08) m_mask[63:32] = bus_wdata;
        else if (bus_addr == 8'h0C) m_mask[31:0]  = bus_wdata;
        else if (bus_addr == 8'h10) m_frc[63:32]  = bus_wdata;
        else if (bus_addr == 8'h14) m_frc[31:0]   = bus_wdata;
      end
    end
  end

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    if (a >= 8'h40 && a < 8'h80) return {24'd0, m_prio[a - 8'h40]};
    case (a)
      8'h00: return m_pend[63:32];
      8'h04: return m_pend[31:0];
      8'h08: return m_mask[63:32];
      8'h0C: return m_mask[31:0];
      8'h10: return m_frc[63:32];
      8'h14: return m_frc[31:0];
      8'hE0: return {24'd0, m_vec};
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done) begin
      check("R4/R5 level vs model", {24'd0, irq_level}, {24'd0, m_lvl});
      check("R4/R5 vector vs model", {24'd0, irq_vector}, {24'd0, m_vec});
    end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk); bus_addr = a; #1;
    check(tag, bus_rdata, ref_read(a));
  endtask

  task automatic rd_exp(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    rd_exp("R10 mask hi after reset", 8'h08, 32'hFFFF_FFFF);
    rd_exp("R10 force lo after reset", 8'h14, 32'h0);
    rd_exp("R10 prio 7 after reset", 8'h47, 32'h0);
    check("R10 level after reset", {24'd0, irq_level}, 32'd0);
    rd_exp("R9 ack vector idle", 8'hE0, 32'd24);

    // R6 mask halves
    wr(8'h08, 32'h0000_0000); wr(8'h0C, 32'h0000_0000);
    rd_exp("R6 mask lo written", 8'h0C, 32'h0);
    // R3 priority store and readback
    wr(8'h45, 32'hFFFF_FF07); wr(8'h49, 32'h7);
    rd_exp("R3 prio 5 readback", 8'h45, 32'h7);
    // R4 tie: sources 5 and 9 both at 7
    @(negedge clk); irq_in = (64'd1 << 5) | (64'd1 << 9);
    settle();
    check("R4 tie goes to higher index", {24'd0, irq_vector}, 32'd73);
    rd_exp("R1 pending lo follows lines", 8'h04, 32'h0000_0220);
    rd_exp("R9 ack vector active", 8'hE0, 32'd73);
    // R3 zero priority disables the winner
    wr(8'h49, 32'h0); settle();
    check("R3 zero prio disables source", {24'd0, irq_vector}, 32'd69);
    // R2 mask excludes source
    wr(8'h0C, 32'h0000_0020); settle();
    check("R2 masked source idle", {24'd0, irq_level}, 32'd0);
    // R7 force source 33 with no request line
    wr(8'h61, 32'h2); wr(8'h10, 32'h0000_0002); settle();
    check("R7 forced source wins", {24'd0, irq_vector}, 32'd97);
    rd_exp("R7 force hi readback", 8'h10, 32'h2);
    // R8 ignored writes
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h20, 32'hDEAD_BEEF);
    rd_exp("R8 pending write ignored", 8'h04, 32'h0000_0220);
    rd_exp("R8 unmapped read zero", 8'h20, 32'h0);
    rd_exp("R8 mask untouched", 8'h0C, 32'h0000_0020);

    // Random patterns with narrow priority range for ties
    for (int n = 0; n < 300; n++) begin
      int k;
      k = int'($urandom_range(0, 5));
      if (k == 0) wr(8'h40 + 8'($urandom_range(0, 63)), $urandom_range(0, 3));
      else if (k == 1) wr(8'h08 + 8'(4 * $urandom_range(0, 1)), $urandom & $urandom);
      else if (k == 2) wr(8'h10 + 8'(4 * $urandom_range(0, 1)), $urandom & $urandom & $urandom);
      else if (k == 3) rd("R1/R6/R7/R3 random readback", (n % 2 == 0) ? 8'h00 + 8'(4 * $urandom_range(0, 5)) : 8'h40 + 8'($urandom_range(0, 63)));
      else begin
        @(negedge clk); irq_in = {$urandom, $urandom};
      end
      if (n % 10 == 0) rd("R9 random ack", 8'hE0);
    end
    settle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule